// File: doc/BRIEF.md
# Token-Ring Depth-Expansion FIFO

This block builds one deep first-in first-out buffer out of several identical storage slices that are linked in a ring. Each slice has its own memory, its own read and write pointers and its own local empty and full flags. No address decoder picks a slice. Two tokens circulate around the ring instead: one grants write permission and one grants read permission. The shared write and read strobes reach every slice, but only the slice that owns the matching token acts on them.

When the write-token owner stores a word in its last location, it sends a one-cycle pulse to the next slice in the ring, which owns the token from the following cycle. The read token moves the same way. At reset, only the slice strapped as first-load owns both tokens, and all pointers return to location zero. The wrapper builds the composite flags by combining the per-slice flags. It also returns read data from whichever slice served the read.

With a single slice, the wrapper builds the standalone variant. That slice keeps both tokens permanently and never emits a handoff pulse. Half-full and retransmit functions do not exist in this block.

Top module: `dxf_ring`

## Requirements
- R1: While `rst` is sampled high, and in the first cycle after it is released, `empty` is 1, `full` is 0 and `rd_valid` is 0. Only the first-load slice (index `FIRST_SLICE`) owns the write and read tokens, and every pointer is at location zero.
- R2: A write strobe that arrives while `full` is 1 is ignored. The word never appears at the read side, and the stored words keep their order.
- R3: Words leave in exactly the order they were accepted, across all slices of the ring.
- R4: Exactly one slice owns the write token at any time. A write that lands in a slice's last location moves the token to the next slice in the ring index order (the last slice wraps to slice 0), effective the cycle after that write.
- R5: Exactly one slice owns the read token at any time. A read from a slice's last location moves the token to the next slice in the same ring order, effective the cycle after that read.
- R6: `full` is 1 exactly when every slice is locally full. Starting from empty, this occurs after NSLICE*DEPTH accepted writes and not before.
- R7: `empty` is 1 exactly when every slice is locally empty. A read strobe while `empty` is 1 produces no `rd_valid`.
- R8: A read accepted at a clock edge presents its word on `rd_data` with `rd_valid` = 1 during the cycle after that edge. The flags reflect an accepted operation in that same cycle.
- R9: A write strobe and a read strobe in the same cycle are each accepted on their own condition. The write is taken if `full` is 0, and the read is taken if `empty` is 0.
- R10: With NSLICE = 1, the single slice keeps both tokens, wraps its own pointers and behaves as a DEPTH-word FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | WIDTH | Word read out, valid while rd_valid is 1 |
| rd_valid | output | 1 | High for one cycle after each accepted read |
| full | output | 1 | Composite full, AND of every slice's full flag |
| empty | output | 1 | Composite empty, AND of every slice's empty flag |

## Verification
Every result of this block is due one cycle after the clock edge that accepts a strobe. At that edge the counts, flags and token registers update, and the memory's registered read port captures the word. The bench drives the strobes on the falling edge and checks each result 1 ns after the next rising edge. Its model updates queue occupancy in the same step, so rd_valid, rd_data and both flags are compared in the exact cycle they become due. Token handoffs are not observed directly. Fill-and-drain sweeps at every level from 1 to 24, and a long mixed pattern that crosses every slice boundary many times, would produce misordered data if a token moved early, late or to the wrong slice.

// File: rtl/dxf_pkg.sv
package dxf_pkg;

  // Index of the slice that feeds slice i in a ring of n slices.
  function automatic int ring_prev(input int i, input int n);
    return (i + n - 1) % n;
  endfunction

endpackage

// File: rtl/dxf_store.sv
// Simple dual-port storage with a registered read port (block RAM style).
module dxf_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dxf_token.sv
// Ownership register for one circulating permission token.
module dxf_token #(
  parameter bit SOLO = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic first_n,   // 0: this slice starts with the token
  input  logic take_in,   // pulse from the previous slice
  input  logic give,      // this slice just used its last location
  output logic owned,
  output logic pass_out   // pulse to the next slice
);

  logic owned_nxt;

  always_comb begin
    if (SOLO) owned_nxt = 1'b1;
    else      owned_nxt = (owned & ~give) | take_in;
  end

  always_ff @(posedge clk) begin
    if (rst) owned <= SOLO | ~first_n;
    else     owned <= owned_nxt;
  end

  assign pass_out = give & ~SOLO;

endmodule

// File: rtl/dxf_slice.sv
// One storage slice: pointers, local flags and the two tokens.
module dxf_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  parameter bit SOLO  = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             wtok_in,
  input  logic             rtok_in,
  output logic             wtok_out,
  output logic             rtok_out,
  output logic             rd_take,
  output logic [WIDTH-1:0] q,
  output logic             loc_full,
  output logic             loc_empty,
  output logic             own_w,
  output logic             own_r
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          wr_take, w_last, r_last;

  assign wr_take = wr_en & own_w & ~loc_full;
  assign rd_take = rd_en & own_r & ~loc_empty;
  assign w_last  = wr_take & (wptr == LAST);
  assign r_last  = rd_take & (rptr == LAST);

  dxf_token #(.SOLO(SOLO)) u_wtok (
    .clk(clk), .rst(rst), .first_n(first_n),
    .take_in(wtok_in), .give(w_last),
    .owned(own_w), .pass_out(wtok_out)
  );

  dxf_token #(.SOLO(SOLO)) u_rtok (
    .clk(clk), .rst(rst), .first_n(first_n),
    .take_in(rtok_in), .give(r_last),
    .owned(own_r), .pass_out(rtok_out)
  );

  dxf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_take), .waddr(wptr), .wdata(wr_data),
    .re(rd_take), .raddr(rptr), .rdata(q)
  );

  always_comb begin
    cnt_nxt = cnt;
    if (wr_take && !rd_take) cnt_nxt = cnt + CW'(1);
    if (rd_take && !wr_take) cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      loc_full  <= 1'b0;
      loc_empty <= 1'b1;
    end else begin
      if (wr_take) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (rd_take) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      cnt       <= cnt_nxt;
      loc_full  <= (cnt_nxt == CFULL);
      loc_empty <= (cnt_nxt == '0);
    end
  end

endmodule

// File: rtl/dxf_ring.sv
// Ring of FIFO slices joined by write and read token links.
module dxf_ring #(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 8,
  parameter int NSLICE      = 3,
  parameter int FIRST_SLICE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty
);

  import dxf_pkg::*;

  localparam bit SOLO = (NSLICE == 1);

  logic [NSLICE-1:0] wtok_o, rtok_o, take_v, full_v, empty_v;
  logic [NSLICE-1:0] hold_w, hold_r, sel_q;
  logic [WIDTH-1:0]  q_v [NSLICE];

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int PREV = ring_prev(i, NSLICE);
    dxf_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SOLO(SOLO)) u_slice (
      .clk(clk), .rst(rst),
      .first_n(i != FIRST_SLICE),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .wtok_in(wtok_o[PREV]), .rtok_in(rtok_o[PREV]),
      .wtok_out(wtok_o[i]), .rtok_out(rtok_o[i]),
      .rd_take(take_v[i]), .q(q_v[i]),
      .loc_full(full_v[i]), .loc_empty(empty_v[i]),
      .own_w(hold_w[i]), .own_r(hold_r[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= take_v;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLICE; i++)
      if (sel_q[i]) rd_data = rd_data | q_v[i];
  end

  assign rd_valid = |sel_q;
  assign full     = &full_v;
  assign empty    = &empty_v;

endmodule

// File: rtl/dxf_ring_chk.sv
module dxf_ring_chk #(
  parameter int NSLICE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic              rd_valid,
  input logic [NSLICE-1:0] hold_w,
  input logic [NSLICE-1:0] hold_r
);

  function automatic logic [NSLICE-1:0] rotl(input logic [NSLICE-1:0] v);
    logic [NSLICE-1:0] r;
    for (int i = 0; i < NSLICE; i++) r[(i + 1) % NSLICE] = v[i];
    return r;
  endfunction

  assert_one_wtok_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(hold_w) == 1);

  assert_one_rtok_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(hold_r) == 1);

  assert_wtok_step_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_w != $past(hold_w)) |-> (hold_w == rotl($past(hold_w))));

  assert_rtok_step_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_r != $past(hold_r)) |-> (hold_r == rotl($past(hold_r))));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> full);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> !rd_valid);

  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  assert_flags_apart_R6: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

bind dxf_ring dxf_ring_chk #(.NSLICE(NSLICE)) u_dxf_ring_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .rd_valid(rd_valid),
  .hold_w(hold_w), .hold_r(hold_r)
);

// File: tb/dxf_ring_bench.sv
`timescale 1ns/1ps
module dxf_ring_bench;

  localparam int W   = 9;
  localparam int D   = 8;
  localparam int N   = 3;
  localparam int CAP = N * D;
  localparam int SD  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic         rd_valid, full, empty;

  logic         s_wr_en = 1'b0, s_rd_en = 1'b0;
  logic [W-1:0] s_wr_data = '0, s_rd_data;
  logic         s_rd_valid, s_full, s_empty;

  dxf_ring #(.WIDTH(W), .DEPTH(D), .NSLICE(N)) u_dxf_ring (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty)
  );

  dxf_ring #(.WIDTH(W), .DEPTH(SD), .NSLICE(1)) u_dxf_ring_solo (
    .clk(clk), .rst(rst), .wr_en(s_wr_en), .wr_data(s_wr_data), .rd_en(s_rd_en),
    .rd_data(s_rd_data), .rd_valid(s_rd_valid), .full(s_full), .empty(s_empty)
  );

  int checks = 0, failures = 0;
  int mq[$];
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k);
    return W'((k * 37 + 5) % 512);
  endfunction

  // One cycle: drive at the falling edge, check 1 ns after the rising edge.
  task automatic step(input logic w, input logic r, input string tag);
    bit aw, ar;
    int exp_d;
    logic [W-1:0] d;
    d = pat(seq);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    aw = w && (mq.size() < CAP);
    ar = r && (mq.size() > 0);
    exp_d = ar ? mq[0] : 0;
    if (w) seq++;
    @(posedge clk); #1;
    if (ar) void'(mq.pop_front());
    if (aw) mq.push_back(int'(d));
    chk(rd_valid === ar, {tag, " R8 rd_valid"}, int'(rd_valid), int'(ar));
    if (ar) chk(int'(rd_data) == exp_d, {tag, " R3 data order"}, int'(rd_data), exp_d);
    chk(full === (mq.size() == CAP), {tag, " R6 full"}, int'(full), int'(mq.size() == CAP));
    chk(empty === (mq.size() == 0), {tag, " R7 empty"}, int'(empty), int'(mq.size() == 0));
  endtask

  initial begin : watchdog
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state while rst is held
    chk(empty === 1'b1, "R1 empty at reset", int'(empty), 1);
    chk(full === 1'b0, "R1 full at reset", int'(full), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid at reset", int'(rd_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(empty === 1'b1 && full === 1'b0, "R1 flags after release", int'({full, empty}), 1);

    // R7: read while empty gives nothing
    step(1'b0, 1'b1, "R7 underflow");

    // R6/R2: fill to capacity, then push past it; ignored word must not emerge
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, "R6 fill");
    step(1'b1, 1'b0, "R2 overflow");
    step(1'b1, 1'b0, "R2 overflow");
    // R4/R5: draining crosses both slice boundaries
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, "R5 drain");
    step(1'b0, 1'b1, "R7 underflow");

    // R4/R5 sweep: every fill level, tokens start from every offset
    for (int lvl = 1; lvl <= CAP; lvl++) begin
      for (int i = 0; i < lvl; i++) step(1'b1, 1'b0, "R4 sweep");
      for (int i = 0; i < lvl; i++) step(1'b0, 1'b1, "R5 sweep");
    end

    // R9: simultaneous strobes, including at empty and at full
    step(1'b1, 1'b1, "R9 both at empty");
    for (int i = 0; i < 600; i++)
      step((i % 7) != 3, ((i % 5) == 0) || ((i / 40) % 2 == 1), "R9 mixed");
    while (mq.size() < CAP) step(1'b1, 1'b0, "R9 refill");
    step(1'b1, 1'b1, "R9 both at full");
    while (mq.size() > 0) step(1'b0, 1'b1, "R9 drain");

    // R10: single-slice variant keeps both tokens and wraps on its own
    for (int lap = 0; lap < 3; lap++) begin
      for (int i = 0; i <= SD; i++) begin
        @(negedge clk); s_wr_en = 1'b1; s_wr_data = W'(lap * 16 + i);
        @(posedge clk); #1;
      end
      chk(s_full === 1'b1, "R10 solo full", int'(s_full), 1);
      for (int i = 0; i < SD; i++) begin
        @(negedge clk); s_wr_en = 1'b0; s_rd_en = 1'b1;
        @(posedge clk); #1;
        chk(s_rd_valid === 1'b1 && int'(s_rd_data) == lap * 16 + i,
            "R10 solo order", int'(s_rd_data), lap * 16 + i);
      end
      @(negedge clk); s_rd_en = 1'b0;
      chk(s_empty === 1'b1, "R10 solo empty", int'(s_empty), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule